// File: doc/BRIEF.md
# Speculative Auto-Step Pointer Unit

This unit holds two indirect address pointers, A and B, for an in-order pipeline. The decoder marks each incoming instruction's source and destination fields with the pointer they take, if any, and a step mode. When the instruction is accepted into the second stage, the unit replaces the marked fields with pointer-derived addresses. In the same clock edge it moves the pointers up or down by one. This step is speculative.

Each in-flight slot (second and third stage) keeps a copy of both pointers as they stood before its own step. A cancel strobe aimed at one of those stages undoes the step. Once an instruction has moved past the third stage, its step is permanent. A cancel arriving then changes nothing. The rewritten fields leave the unit with the instruction as it occupies the third stage, where register reads use them.

Top module: `ptr_autoinc_unit`

## Requirements
- R1: Reset (synchronous, active high) clears both pointers to zero and empties every slot, so `rd_vld_o` is 0.
- R2: Pointer select codes are 2'b01 for A and 2'b10 for B. The codes 2'b00 and 2'b11 pass the raw field through untouched. A field accepted at one edge appears on `rd_s_o`/`rd_d_o` with `rd_vld_o` high after the next unstalled edge. The pointer changes at the accepting edge itself.
- R3: Step code 2'b00 is post-increment and 2'b01 is post-decrement. The field receives the pointer's old value, and the pointer then moves by one.
- R4: Step code 2'b10 is pre-increment and 2'b11 is pre-decrement. The field receives the already-stepped value, which is also the pointer's new value.
- R5: When source and destination select the same pointer, both fields receive the identical value. The source's step code governs, and the pointer moves only once.
- R6: When source and destination select different pointers, each pointer steps by its own field's code in the same edge.
- R7: A cancel of the second stage (`cancel_i[0]`) restores both pointers to the values they held before that stage's instruction stepped them. The instruction never reaches `rd_vld_o`.
- R8: A cancel of the third stage (`cancel_i[1]`) also flushes the younger second stage. It restores the pointers to the shadow of the oldest cancelled slot that stepped a pointer.
- R9: An instruction that has left the third stage keeps its step. Cancels arriving after that leave the pointers unchanged.
- R10: While `stall_i` is high with no cancel, pointers, slots and outputs hold. A held instruction steps exactly once when the stall drops.
- R11: With no accepted instruction and no cancel, the pointers hold their values.
- R12: Pointer arithmetic wraps modulo 2^PTR_W: decrementing 0 gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | Instruction entering the second stage |
| s_sel_i | input | 2 | Source field pointer select |
| s_op_i | input | 2 | Source field step code |
| s_raw_i | input | PTR_W | Source field as fetched |
| d_sel_i | input | 2 | Destination field pointer select |
| d_op_i | input | 2 | Destination field step code |
| d_raw_i | input | PTR_W | Destination field as fetched |
| stall_i | input | 1 | Pipeline stall, freezes the slots |
| cancel_i | input | NSLOT | Per-stage cancel, bit 0 second stage, bit 1 third stage |
| rd_vld_o | output | 1 | Third stage holds a live instruction |
| rd_s_o | output | PTR_W | Rewritten source field for register read |
| rd_d_o | output | PTR_W | Rewritten destination field for register read |
| ptr_a_o | output | PTR_W | Current value of pointer A |
| ptr_b_o | output | PTR_W | Current value of pointer B |

## Verification
The hardest state to reach is two stepping instructions in flight at once, followed by a cancel of the older one. The rollback must then skip the younger slot's shadow and return to the state before both steps. The stimulus issues two pointer-stepping instructions on back-to-back cycles and pulses the third-stage cancel on the following cycle. A second tricky point is a cancel that arrives just after an instruction has left the third stage. The bench waits exactly two edges after issue before pulsing both cancel bits, then confirms that the step survives.

// File: rtl/ptr_autoinc_pkg.sv
package ptr_autoinc_pkg;

    typedef enum logic [1:0] {
        SEL_RAW  = 2'b00,
        SEL_A    = 2'b01,
        SEL_B    = 2'b10,
        SEL_RSV  = 2'b11
    } ptr_sel_e;

    typedef enum logic [1:0] {
        OP_POST_INC = 2'b00,
        OP_POST_DEC = 2'b01,
        OP_PRE_INC  = 2'b10,
        OP_PRE_DEC  = 2'b11
    } ptr_op_e;

    function automatic logic op_is_pre(input ptr_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_dec(input ptr_op_e op);
        return op[0];
    endfunction

    function automatic logic sel_is_ptr(input ptr_sel_e sel);
        return (sel == SEL_A) || (sel == SEL_B);
    endfunction

endpackage

// File: rtl/ptr_rewrite.sv
module ptr_rewrite
    import ptr_autoinc_pkg::*;
#(
    parameter int PTR_W = 9
) (
    input  logic [PTR_W-1:0] cur_a_i,
    input  logic [PTR_W-1:0] cur_b_i,
    input  logic [1:0]       s_sel_i,
    input  logic [1:0]       s_op_i,
    input  logic [PTR_W-1:0] s_raw_i,
    input  logic [1:0]       d_sel_i,
    input  logic [1:0]       d_op_i,
    input  logic [PTR_W-1:0] d_raw_i,
    output logic [PTR_W-1:0] fld_s_o,
    output logic [PTR_W-1:0] fld_d_o,
    output logic [PTR_W-1:0] nxt_a_o,
    output logic [PTR_W-1:0] nxt_b_o,
    output logic             steps_o
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    ptr_sel_e ssel, dsel;
    ptr_op_e  sop, dop;

    assign ssel = ptr_sel_e'(s_sel_i);
    assign dsel = ptr_sel_e'(d_sel_i);
    assign sop  = ptr_op_e'(s_op_i);
    assign dop  = ptr_op_e'(d_op_i);

    function automatic logic [PTR_W-1:0] stepped(input logic [PTR_W-1:0] v, input ptr_op_e op);
        return op_is_dec(op) ? v - ONE : v + ONE;
    endfunction

    function automatic logic [PTR_W-1:0] pick(input ptr_sel_e sel, input logic [PTR_W-1:0] a,
                                              input logic [PTR_W-1:0] b);
        return (sel == SEL_A) ? a : b;
    endfunction

    logic shared;
    assign shared = sel_is_ptr(ssel) && (ssel == dsel);

    always_comb begin
        if (sel_is_ptr(ssel)) begin
            fld_s_o = op_is_pre(sop) ? stepped(pick(ssel, cur_a_i, cur_b_i), sop)
                                     : pick(ssel, cur_a_i, cur_b_i);
        end else begin
            fld_s_o = s_raw_i;
        end

        if (shared) begin
            fld_d_o = fld_s_o;
        end else if (sel_is_ptr(dsel)) begin
            fld_d_o = op_is_pre(dop) ? stepped(pick(dsel, cur_a_i, cur_b_i), dop)
                                     : pick(dsel, cur_a_i, cur_b_i);
        end else begin
            fld_d_o = d_raw_i;
        end

        nxt_a_o = cur_a_i;
        nxt_b_o = cur_b_i;
        if (ssel == SEL_A)      nxt_a_o = stepped(cur_a_i, sop);
        else if (dsel == SEL_A) nxt_a_o = stepped(cur_a_i, dop);
        if (ssel == SEL_B)      nxt_b_o = stepped(cur_b_i, sop);
        else if (dsel == SEL_B) nxt_b_o = stepped(cur_b_i, dop);

        steps_o = sel_is_ptr(ssel) || sel_is_ptr(dsel);
    end

endmodule

// File: rtl/ptr_stage_reg.sv
module ptr_stage_reg #(
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clr_i,
    input  logic          hold_i,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] q_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            q_o <= '0;
        end else if (!hold_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/ptr_autoinc_unit.sv
module ptr_autoinc_unit
    import ptr_autoinc_pkg::*;
#(
    parameter int PTR_W = 9,
    parameter int NSLOT = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             in_vld_i,
    input  logic [1:0]       s_sel_i,
    input  logic [1:0]       s_op_i,
    input  logic [PTR_W-1:0] s_raw_i,
    input  logic [1:0]       d_sel_i,
    input  logic [1:0]       d_op_i,
    input  logic [PTR_W-1:0] d_raw_i,
    input  logic             stall_i,
    input  logic [NSLOT-1:0] cancel_i,
    output logic             rd_vld_o,
    output logic [PTR_W-1:0] rd_s_o,
    output logic [PTR_W-1:0] rd_d_o,
    output logic [PTR_W-1:0] ptr_a_o,
    output logic [PTR_W-1:0] ptr_b_o
);

    typedef struct packed {
        logic             live;
        logic             stepped;
        logic [PTR_W-1:0] shadow_a;
        logic [PTR_W-1:0] shadow_b;
        logic [PTR_W-1:0] fld_s;
        logic [PTR_W-1:0] fld_d;
    } slot_t;

    localparam int SLOT_W = $bits(slot_t);

    logic [PTR_W-1:0] ptr_a, ptr_b;
    logic [PTR_W-1:0] new_s, new_d, nxt_a, nxt_b;
    logic             new_steps;
    logic             any_cancel;
    slot_t            entry;

    logic [SLOT_W-1:0] slot_q [NSLOT];
    slot_t             slots  [NSLOT];
    logic [NSLOT-1:0]  covered;

    ptr_rewrite #(.PTR_W(PTR_W)) u_rewrite (
        .cur_a_i (ptr_a),
        .cur_b_i (ptr_b),
        .s_sel_i (s_sel_i),
        .s_op_i  (s_op_i),
        .s_raw_i (s_raw_i),
        .d_sel_i (d_sel_i),
        .d_op_i  (d_op_i),
        .d_raw_i (d_raw_i),
        .fld_s_o (new_s),
        .fld_d_o (new_d),
        .nxt_a_o (nxt_a),
        .nxt_b_o (nxt_b),
        .steps_o (new_steps)
    );

    assign any_cancel = |cancel_i;

    always_comb begin
        entry          = '0;
        entry.live     = in_vld_i;
        entry.stepped  = in_vld_i && new_steps;
        entry.shadow_a = ptr_a;
        entry.shadow_b = ptr_b;
        entry.fld_s    = new_s;
        entry.fld_d    = new_d;
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic             clr;
        logic [SLOT_W-1:0] din;

        assign covered[k] = |cancel_i[NSLOT-1:k];

        if (k == 0) begin : g_head
            assign clr = any_cancel;
            assign din = SLOT_W'(entry);
        end else begin : g_tail
            assign clr = covered[k] || (cancel_i[k-1] && !stall_i);
            assign din = slot_q[k-1];
        end

        ptr_stage_reg #(.DW(SLOT_W)) u_reg (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .clr_i  (clr),
            .hold_i (stall_i),
            .d_i    (din),
            .q_o    (slot_q[k])
        );

        assign slots[k] = slot_t'(slot_q[k]);
    end

    logic             restore;
    logic [PTR_W-1:0] back_a, back_b;

    always_comb begin
        restore = 1'b0;
        back_a  = ptr_a;
        back_b  = ptr_b;
        for (int k = 0; k < NSLOT; k++) begin
            if (covered[k] && slots[k].stepped) begin
                restore = 1'b1;
                back_a  = slots[k].shadow_a;
                back_b  = slots[k].shadow_b;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ptr_a <= '0;
            ptr_b <= '0;
        end else if (restore) begin
            ptr_a <= back_a;
            ptr_b <= back_b;
        end else if (!any_cancel && !stall_i && in_vld_i) begin
            ptr_a <= nxt_a;
            ptr_b <= nxt_b;
        end
    end

    assign rd_vld_o = slots[NSLOT-1].live;
    assign rd_s_o   = slots[NSLOT-1].fld_s;
    assign rd_d_o   = slots[NSLOT-1].fld_d;
    assign ptr_a_o  = ptr_a;
    assign ptr_b_o  = ptr_b;

endmodule

// File: rtl/ptr_autoinc_chk.sv
module ptr_autoinc_chk #(
    parameter int PTR_W = 9,
    parameter int NSLOT = 2
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             in_vld_i,
    input logic [1:0]       s_sel_i,
    input logic [1:0]       s_op_i,
    input logic [PTR_W-1:0] s_raw_i,
    input logic [1:0]       d_sel_i,
    input logic [1:0]       d_op_i,
    input logic [PTR_W-1:0] d_raw_i,
    input logic             stall_i,
    input logic [NSLOT-1:0] cancel_i,
    input logic             rd_vld_o,
    input logic [PTR_W-1:0] rd_s_o,
    input logic [PTR_W-1:0] rd_d_o,
    input logic [PTR_W-1:0] ptr_a_o,
    input logic [PTR_W-1:0] ptr_b_o
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (ptr_a_o == '0 && ptr_b_o == '0 && !rd_vld_o)); // R1

    AST_SINGLE_STEP_A: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_vld_i && !stall_i && cancel_i == '0) |=>
        (ptr_a_o == $past(ptr_a_o) || ptr_a_o == $past(ptr_a_o) + ONE
         || ptr_a_o == $past(ptr_a_o) - ONE)); // R5

    AST_SINGLE_STEP_B: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_vld_i && !stall_i && cancel_i == '0) |=>
        (ptr_b_o == $past(ptr_b_o) || ptr_b_o == $past(ptr_b_o) + ONE
         || ptr_b_o == $past(ptr_b_o) - ONE)); // R6

    AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i)
        (stall_i && cancel_i == '0) |=>
        ($stable(ptr_a_o) && $stable(ptr_b_o) && $stable(rd_vld_o))); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!in_vld_i && cancel_i == '0) |=> ($stable(ptr_a_o) && $stable(ptr_b_o))); // R11

    AST_OLDEST_FLUSH: assert property (@(posedge clk_i) disable iff (rst_i)
        cancel_i[NSLOT-1] |=> !rd_vld_o); // R8

    AST_HEAD_FLUSH: assert property (@(posedge clk_i) disable iff (rst_i)
        (cancel_i[0] && !stall_i) |=> !rd_vld_o); // R7

endmodule

bind ptr_autoinc_unit ptr_autoinc_chk #(.PTR_W(PTR_W), .NSLOT(NSLOT)) u_chk (.*);

// File: tb/ptr_autoinc_unit_test.sv
module ptr_autoinc_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 9;
    localparam int N = 2;

    localparam logic [1:0] RAW = 2'b00, PA = 2'b01, PB = 2'b10;
    localparam logic [1:0] POI = 2'b00, POD = 2'b01, PRI = 2'b10, PRD = 2'b11;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_vld = 1'b0;
    logic [1:0]   s_sel = '0, s_op = '0, d_sel = '0, d_op = '0;
    logic [W-1:0] s_raw = '0, d_raw = '0;
    logic         stall = 1'b0;
    logic [N-1:0] cancel = '0;
    logic         rd_vld;
    logic [W-1:0] rd_s, rd_d, ptr_a, ptr_b;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_autoinc_unit #(.PTR_W(W), .NSLOT(N)) uut (
        .clk_i(clk), .rst_i(rst), .in_vld_i(in_vld),
        .s_sel_i(s_sel), .s_op_i(s_op), .s_raw_i(s_raw),
        .d_sel_i(d_sel), .d_op_i(d_op), .d_raw_i(d_raw),
        .stall_i(stall), .cancel_i(cancel),
        .rd_vld_o(rd_vld), .rd_s_o(rd_s), .rd_d_o(rd_d),
        .ptr_a_o(ptr_a), .ptr_b_o(ptr_b)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] ss, input logic [1:0] so, input logic [W-1:0] sr,
                         input logic [1:0] ds, input logic [1:0] dop, input logic [W-1:0] dr);
        s_sel = ss; s_op = so; s_raw = sr;
        d_sel = ds; d_op = dop; d_raw = dr;
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic pulse_cancel(input logic [N-1:0] c);
        cancel = c;
        @(negedge clk);
        cancel = '0;
    endtask

    task automatic t_reset;
        check("R1 ptr_a after reset", ptr_a, 0);
        check("R1 ptr_b after reset", ptr_b, 0);
        check("R1 rd_vld after reset", rd_vld, 0);
    endtask

    task automatic t_post;
        issue(PA, POI, 9'h1AB, RAW, POI, 9'h0CD);
        check("R3 post-inc steps A", ptr_a, 1);
        @(negedge clk);
        check("R2 rd_vld one edge later", rd_vld, 1);
        check("R3 post-inc gives old A", rd_s, 0);
        check("R2 raw dest passes", rd_d, 'h0CD);
        issue(RAW, POI, 9'h055, PB, POD, 9'h000);
        check("R12 post-dec wraps B", ptr_b, 511);
        @(negedge clk);
        check("R3 post-dec gives old B", rd_d, 0);
        check("R2 raw source passes", rd_s, 'h055);
    endtask

    task automatic t_pre;
        issue(PA, PRI, 9'h000, RAW, POI, 9'h011);
        check("R4 pre-inc steps A", ptr_a, 2);
        @(negedge clk);
        check("R4 pre-inc gives new A", rd_s, 2);
        issue(RAW, POI, 9'h022, PB, PRD, 9'h000);
        check("R4 pre-dec steps B", ptr_b, 510);
        @(negedge clk);
        check("R4 pre-dec gives new B", rd_d, 510);
    endtask

    task automatic t_same;
        issue(PA, POI, 9'h000, PA, PRD, 9'h000);
        check("R5 one step only", ptr_a, 3);
        @(negedge clk);
        check("R5 source field", rd_s, 2);
        check("R5 dest matches source", rd_d, 2);
    endtask

    task automatic t_diff;
        issue(PA, PRI, 9'h000, PB, POD, 9'h000);
        check("R6 A stepped", ptr_a, 4);
        check("R6 B stepped", ptr_b, 509);
        @(negedge clk);
        check("R6 source from A", rd_s, 4);
        check("R6 dest from B", rd_d, 510);
    endtask

    task automatic t_cancel_head;
        issue(PA, POI, 9'h000, PB, PRI, 9'h000);
        check("R7 speculative A", ptr_a, 5);
        pulse_cancel(2'b01);
        check("R7 A rolled back", ptr_a, 4);
        check("R7 B rolled back", ptr_b, 509);
        check("R7 no issue", rd_vld, 0);
        @(negedge clk);
        check("R7 still no issue", rd_vld, 0);
    endtask

    task automatic t_cancel_oldest;
        issue(PA, POI, 9'h000, RAW, POI, 9'h000);
        issue(PB, POI, 9'h000, RAW, POI, 9'h000);
        check("R8 both steps applied A", ptr_a, 5);
        check("R8 both steps applied B", ptr_b, 510);
        pulse_cancel(2'b10);
        check("R8 A back to oldest", ptr_a, 4);
        check("R8 B back to oldest", ptr_b, 509);
        check("R8 stage flushed", rd_vld, 0);
        @(negedge clk);
        check("R8 younger flushed", rd_vld, 0);
    endtask

    task automatic t_late_cancel;
        issue(PA, PRD, 9'h000, RAW, POI, 9'h000);
        @(negedge clk);
        check("R9 reached read stage", rd_s, 3);
        @(negedge clk);
        pulse_cancel(2'b11);
        check("R9 retired step kept", ptr_a, 3);
    endtask

    task automatic t_stall;
        stall = 1'b1;
        s_sel = PA; s_op = POI; d_sel = RAW; d_op = POI;
        in_vld = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 no step under stall", ptr_a, 3);
        stall = 1'b0;
        @(negedge clk);
        in_vld = 1'b0;
        check("R10 single step on release", ptr_a, 4);
        stall = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 held in second stage", rd_vld, 0);
        check("R10 no double step", ptr_a, 4);
        stall = 1'b0;
        @(negedge clk);
        check("R10 advances after stall", rd_vld, 1);
        check("R10 field after stall", rd_s, 3);
    endtask

    task automatic t_idle;
        repeat (3) @(negedge clk);
        check("R11 A holds idle", ptr_a, 4);
        check("R11 B holds idle", ptr_b, 509);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_post();
        t_pre();
        t_same();
        t_diff();
        t_cancel_head();
        t_cancel_oldest();
        t_late_cancel();
        t_stall();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule